// File: doc/BRIEF.md
# Three-Byte SPI Command Slave

This block is the serial front end of a small register-mapped device. A host talks to it over a four-wire SPI link in mode 0. Every access is one frame of exactly three bytes, sent MSB first while chip select is low: a fixed identification byte, an instruction byte and a data byte. The instruction byte carries a 4-bit opcode and a 2-bit register address. The slave uses that byte to decide whether the frame is a read, a write, or something to ignore.

The SPI pins are brought into the system clock domain through two-flop synchronisers, and all edge detection happens there. For this reason SCK must run at no more than a quarter of the system clock. On a valid read, the block raises a one-cycle read request carrying the register address. It takes the returned byte in that same cycle and shifts it out during the third byte of the frame. The serial output is open drain: the block supplies a drive enable and a level, and an external pull-up sets the idle high. On a valid write, the block records the data byte and issues a single write strobe with address and data only when chip select rises after a complete frame. The registers themselves and any non-volatile timing sit outside this block.

Top module: `spi3_cmd_slave`

## Requirements
- R1: After reset, `sdo_oe`, `wr_stb` and `rd_req` are all low, and no frame is accepted until chip select has gone from high to low.
- R2: A frame of identification byte 0x50, instruction byte {opcode 1100, bits 3:2 = 00, address} and a data byte produces exactly one one-cycle `wr_stb` after chip select rises. The strobe carries that address on `wr_addr` and the data byte on `wr_data`.
- R3: A frame with identification 0x50 and instruction {opcode 1011, 00, address} raises `rd_req` for one cycle with the address on `rd_addr`, after the 16th bit. The byte on `rd_data` in that cycle appears on SDO MSB first during bits 17 to 24. SDO changes only after SCK falling edges and is valid at each following rising edge.
- R4: If the identification byte is anything other than 0x50, the rest of the frame is ignored: no `wr_stb`, no `rd_req`, and `sdo_oe` stays low.
- R5: An opcode other than 1011 or 1100, or a nonzero bit 3 or bit 2 in the instruction byte, makes the frame ignored in the same way.
- R6: Only address 00 (wiper/initial-value) and address 10 (control) are accepted. Address 01 or 11 makes the frame ignored.
- R7: If chip select rises before all 24 bits of a write frame have arrived, no `wr_stb` is issued.
- R8: If more than 24 bits arrive within one chip-select window, the frame is discarded and no `wr_stb` is issued. The next properly framed write is accepted normally.
- R9: `sdo_oe` is high only during an accepted read frame. It is low from the cycle after the synchronised chip select goes high.
- R10: A read frame never produces `wr_stb`, and `wr_stb` is never high while `sdo_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_sdi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low chip select |
| sdo_oe | output | 1 | Serial output drive enable; low means released to the pull-up |
| sdo_lvl | output | 1 | Serial output level while driven |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | ADDR_W | Register address for the read |
| rd_data | input | BYTE_W | Register value, sampled in the `rd_req` cycle |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register address for the write |
| wr_data | output | BYTE_W | Data byte for the write |

## Verification
The bound checker watches several rules on every cycle. The drive enable falls once chip select is seen high. Write strobes and read requests are single-cycle pulses. A strobe always follows a chip-select rise and only ever names a legal address. SDO moves only after a falling SCK edge, and is never driven during a write strobe. Whether a frame is accepted at all depends on its whole content, and only the bench scenarios can show that: the identification match, the opcode and padding bits, the short and overlong frames, and the exact byte shifted out on a read.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int OPC_W = 4;
  localparam logic [7:0] ID_BYTE = 8'h50;

  typedef enum logic [OPC_W-1:0] {
    OPC_READ  = 4'b1011,
    OPC_WRITE = 4'b1100
  } opc_e;

  localparam logic [1:0] ADR_WIPER = 2'b00;
  localparam logic [1:0] ADR_CTRL  = 2'b10;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sdi_bit,
  output logic              rd_req,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int FRAME_BITS = BYTE_W * N_BYTES;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_ID_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_INS_LAST = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, sh_in;
  logic              bad_q, bad_n;
  logic              wr_ok_q, wr_ok_n;
  logic              rd_ok_q, rd_ok_n;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_in;
  logic              rd_req_q, rd_req_n;
  logic              wr_stb_q, wr_stb_n;
  logic [BYTE_W-1:0] wdat_q, wdat_n;
  logic [OPC_W-1:0]  opc_in;
  logic              pad_zero, addr_legal;

  assign sh_in      = {sh_q[BYTE_W-2:0], sdi_bit};
  assign opc_in     = sh_in[BYTE_W-1 -: OPC_W];
  assign addr_in    = sh_in[ADDR_W-1:0];
  assign pad_zero   = (sh_in[BYTE_W-OPC_W-1:ADDR_W] == '0);
  assign addr_legal = (addr_in == ADDR_W'(ADR_WIPER)) || (addr_in == ADDR_W'(ADR_CTRL));

  always_comb begin
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    bad_n    = bad_q;
    wr_ok_n  = wr_ok_q;
    rd_ok_n  = rd_ok_q;
    addr_n   = addr_q;
    wdat_n   = wdat_q;
    rd_req_n = 1'b0;
    wr_stb_n = 1'b0;
    if (cs_fall) begin
      cnt_n   = '0;
      bad_n   = 1'b0;
      wr_ok_n = 1'b0;
      rd_ok_n = 1'b0;
    end else if (cs_rise) begin
      if (wr_ok_q && !bad_q && cnt_q == CNT_FULL) begin
        wr_stb_n = 1'b1;
        wdat_n   = sh_q;
      end
      bad_n   = 1'b1;
      wr_ok_n = 1'b0;
      rd_ok_n = 1'b0;
    end else if (sck_rise && cs_act && !bad_q) begin
      sh_n  = sh_in;
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CNT_ID_LAST && sh_in != BYTE_W'(ID_BYTE)) bad_n = 1'b1;
      if (cnt_q == CNT_INS_LAST) begin
        if (pad_zero && addr_legal && opc_in == OPC_READ) begin
          rd_ok_n  = 1'b1;
          rd_req_n = 1'b1;
          addr_n   = addr_in;
        end else if (pad_zero && addr_legal && opc_in == OPC_WRITE) begin
          wr_ok_n = 1'b1;
          addr_n  = addr_in;
        end else begin
          bad_n = 1'b1;
        end
      end
      if (cnt_q == CNT_FULL) begin
        bad_n   = 1'b1;
        wr_ok_n = 1'b0;
        rd_ok_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      bad_q    <= 1'b1;
      wr_ok_q  <= 1'b0;
      rd_ok_q  <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
      rd_req_q <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      bad_q    <= bad_n;
      wr_ok_q  <= wr_ok_n;
      rd_ok_q  <= rd_ok_n;
      addr_q   <= addr_n;
      wdat_q   <= wdat_n;
      rd_req_q <= rd_req_n;
      wr_stb_q <= wr_stb_n;
    end
  end

  assign rd_req   = rd_req_q;
  assign rd_ok    = rd_ok_q;
  assign acc_addr = addr_q;
  assign wr_stb   = wr_stb_q;
  assign wr_data  = wdat_q;
endmodule

// File: rtl/spi3_tx.sv
module spi3_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              rd_ok,
  input  logic              cs_act,
  input  logic              sck_fall,
  output logic              sdo_oe,
  output logic              sdo_lvl
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] tx_q, tx_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic              drv_q, drv_n;
  logic              lvl_q, lvl_n;

  always_comb begin
    tx_n   = tx_q;
    left_n = left_q;
    drv_n  = drv_q;
    lvl_n  = lvl_q;
    if (load) begin
      tx_n   = load_data;
      left_n = CNT_W'(BYTE_W);
      drv_n  = 1'b0;
    end else if (sck_fall && rd_ok && cs_act && left_q != '0) begin
      lvl_n  = tx_q[BYTE_W-1];
      tx_n   = {tx_q[BYTE_W-2:0], 1'b0};
      left_n = left_q - 1'b1;
      drv_n  = 1'b1;
    end
    if (!cs_act || !rd_ok) drv_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      left_q <= '0;
      drv_q  <= 1'b0;
      lvl_q  <= 1'b1;
    end else begin
      tx_q   <= tx_n;
      left_q <= left_n;
      drv_q  <= drv_n;
      lvl_q  <= lvl_n;
    end
  end

  assign sdo_oe  = drv_q;
  assign sdo_lvl = lvl_q;
endmodule

// File: rtl/spi3_cmd_slave.sv
module spi3_cmd_slave #(
  parameter int BYTE_W      = 8,
  parameter int N_BYTES     = 3,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  input  logic              spi_cs_n,
  output logic              sdo_oe,
  output logic              sdo_lvl,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              cs_s, sck_s, sdi_s;
  logic              cs_d, sck_d;
  logic              cs_rise, cs_fall, sck_rise, sck_fall, cs_act;
  logic              rd_ok;
  logic [ADDR_W-1:0] acc_addr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  spi3_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({spi_cs_n, spi_sck, spi_sdi}),
    .q     (pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign cs_act   = ~cs_s;

  spi3_frame #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .ADDR_W(ADDR_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_act   (cs_act),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .sdi_bit  (sdi_s),
    .rd_req   (rd_req),
    .rd_ok    (rd_ok),
    .acc_addr (acc_addr),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data)
  );

  spi3_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (rd_req),
    .load_data (rd_data),
    .rd_ok     (rd_ok),
    .cs_act    (cs_act),
    .sck_fall  (sck_fall),
    .sdo_oe    (sdo_oe),
    .sdo_lvl   (sdo_lvl)
  );

  assign rd_addr = acc_addr;
  assign wr_addr = acc_addr;
endmodule

// File: rtl/spi3_cmd_slave_chk.sv
module spi3_cmd_slave_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              cs_rise,
  input logic              sck_fall,
  input logic              rd_ok,
  input logic              sdo_oe,
  input logic              sdo_lvl,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr
);
  a_r9_oe_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> $past(rd_ok));

  a_r2_wr_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(cs_rise));

  a_r10_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r10_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sdo_oe);

  a_r3_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r3_sdo_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo_lvl)) |-> $past(sck_fall));

  a_r6_wr_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == ADDR_W'(2'b00) || wr_addr == ADDR_W'(2'b10)));

  a_r6_rd_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr == ADDR_W'(2'b00) || rd_addr == ADDR_W'(2'b10)));
endmodule

bind spi3_cmd_slave spi3_cmd_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .cs_s     (cs_s),
  .cs_rise  (cs_rise),
  .sck_fall (sck_fall),
  .rd_ok    (rd_ok),
  .sdo_oe   (sdo_oe),
  .sdo_lvl  (sdo_lvl),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .wr_stb   (wr_stb),
  .wr_addr  (wr_addr)
);

// File: tb/sim_spi3_cmd_slave.sv
module sim_spi3_cmd_slave;
  localparam int HALF = 6;

  logic       clk;
  logic       rst_n;
  logic       spi_sck, spi_sdi, spi_cs_n;
  logic       sdo_oe, sdo_lvl, rd_req, wr_stb;
  logic [1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] bank [4];

  int n_chk, n_fail;
  int wr_cnt, rd_cnt;
  logic oe_seen;
  logic [1:0] last_wa, last_ra;
  logic [7:0] last_wd;
  logic done;

  spi3_cmd_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
    .spi_cs_n(spi_cs_n), .sdo_oe(sdo_oe), .sdo_lvl(sdo_lvl),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_data = bank[rd_addr];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (wr_stb) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
    if (rd_req) begin rd_cnt++; last_ra = rd_addr; end
    if (sdo_oe) oe_seen = 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    wr_cnt = 0; rd_cnt = 0; oe_seen = 1'b0;
  endtask

  task automatic frame(input logic [23:0] bits, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    clr();
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 24) ? bits[23-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 24) rx = {rx[6:0], sdo_oe ? sdo_lvl : 1'b1};
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 sdo_oe after reset", sdo_oe, 0);
    check("R1 wr_stb after reset", wr_stb, 0);
    check("R1 rd_req after reset", rd_req, 0);
  endtask

  task automatic t_write(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] rx;
    frame({8'h50, 4'b1100, 2'b00, a, d}, 24, rx);
    check("R2 write strobe count", wr_cnt, 1);
    check("R2 write address", last_wa, a);
    check("R2 write data", last_wd, d);
    check("R9 no drive in write frame", oe_seen, 0);
  endtask

  task automatic t_read(input logic [1:0] a, input logic [7:0] v);
    logic [7:0] rx;
    bank[a] = v;
    frame({8'h50, 4'b1011, 2'b00, a, 8'h00}, 24, rx);
    check("R3 read request count", rd_cnt, 1);
    check("R3 read address", last_ra, a);
    check("R3 shifted byte", rx, v);
    check("R10 no strobe on read", wr_cnt, 0);
    check("R9 released after CS high", sdo_oe, 0);
  endtask

  task automatic t_ignored(input string tag, input logic [23:0] bits, input int nbits);
    logic [7:0] rx;
    frame(bits, nbits, rx);
    check({tag, " no strobe"}, wr_cnt, 0);
    check({tag, " no read request"}, rd_cnt, 0);
    check({tag, " SDO released"}, oe_seen, 0);
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_fail = 0;
    spi_sck = 1'b0; spi_sdi = 1'b0; spi_cs_n = 1'b1;
    bank[0] = 8'h00; bank[1] = 8'hFF; bank[2] = 8'h00; bank[3] = 8'hFF;
    clr();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write(2'b00, 8'h77);
    t_write(2'b10, 8'h40);
    t_read(2'b00, 8'h5A);
    t_read(2'b10, 8'hA5);
    t_read(2'b00, 8'h81);
    t_ignored("R4 bad id write", {8'h51, 8'hC0, 8'h33}, 24);
    t_ignored("R4 bad id read", {8'hD0, 8'hB0, 8'h00}, 24);
    t_ignored("R5 bad opcode", {8'h50, 8'hD0, 8'h33}, 24);
    t_ignored("R5 padding bits set", {8'h50, 8'hB4, 8'h00}, 24);
    t_ignored("R6 address 01 read", {8'h50, 8'hB1, 8'h00}, 24);
    t_ignored("R6 address 11 write", {8'h50, 8'hC3, 8'h12}, 24);
    t_ignored("R7 short write", {8'h50, 8'hC0, 8'h12}, 20);
    t_ignored("R8 overlong write", {8'h50, 8'hC0, 8'h12}, 25);
    t_write(2'b10, 8'hC3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule